// File: doc/BRIEF.md
# Indexed IN-endpoint register window

This block is the CPU-facing register window of a small USB device controller that has endpoints 0, 1 and 2. A single 8-bit bus with a 3-bit address reaches every endpoint's IN registers through one shared set of addresses. The CPU first writes the endpoint number to an index register. Later reads and writes at the shared addresses then go to that endpoint's own copy of the max-packet size, the control bits and the loaded-byte count.

Each endpoint tracks how many bytes the CPU has pushed through the FIFO data address. When auto-set is enabled and the count reaches the programmed max-packet size, the endpoint raises its packet-ready flag on its own. Otherwise the CPU sets the flag by writing it. The USB side clears the flag with a one-cycle transmit-done pulse. A flush command drops the count, the flag and the overrun status. Bytes written while a packet is pending are refused and recorded as an overrun.

Endpoint 0 has a reduced register set. It has no max-packet size and no auto-set, so it relies on manual packet-ready only. The FIFO storage itself is outside this block: it keeps the count and the flags only.

Top module: `usb_ep_regbank`

## Requirements
- R1: Writing the index (address 0, bits 1:0) selects the visible endpoint: 0, 1 or 2. The index reads back in bits 1:0 with bits 7:2 zero. While the index is 3, every other address reads 00h and writes to it change nothing.
- R2: After reset, the index and every endpoint's max-packet bytes, auto-set control, packet-ready, overrun and byte count are all zero.
- R3: The 11-bit max-packet size for endpoints 1 and 2 is split across two registers. Its bits 7:0 sit at address 1. Its bits 10:8 sit in bits 2:0 at address 2, where bits 7:3 always read 0.
- R4: With index 0, addresses 1, 2 and 3 read 00h and ignore writes.
- R5: Each endpoint keeps separate state. Writes reach only the indexed endpoint, and changing the index never alters any stored value.
- R6: With auto-set (address 3, bit 7) set, the accepted byte that makes the count equal to a non-zero max-packet size sets packet-ready at the same clock edge.
- R7: With auto-set clear, or for a packet shorter than the max-packet size, packet-ready stays 0. Writing 1 to bit 0 at address 4 sets it, and writing 0 there does not clear it.
- R8: Writing 1 to bit 1 at address 4 (flush) clears the count, packet-ready and overrun of the indexed endpoint. Bit 1 always reads 0.
- R9: A tx_done pulse for an endpoint clears its packet-ready and its count at the next edge. This takes priority over a CPU packet-ready set in the same cycle.
- R10: A write to address 5 (FIFO data) while packet-ready is 1 leaves the count unchanged and sets the sticky overrun bit (address 4, bit 2). Only a flush clears the overrun bit.
- R11: The count reads at address 5 (bits 7:0) and address 6 (bits 2:0 = count bits 10:8). pkt_ready[e] mirrors endpoint e's packet-ready bit (address 4, bit 0).
- R12: When tx_done and a FIFO data write to the same ready endpoint fall in the same cycle, the write is refused and overrun is set. Packet-ready and the count both end at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| tx_done | input | 3 | Per-endpoint one-cycle transmit-done pulse from the USB side |
| pkt_ready | output | 3 | Per-endpoint packet-ready flag |

## Verification
Two paths can act on the same endpoint in one cycle: the USB-side tx_done pulse and a CPU write. That CPU write is either a FIFO data byte or a packet-ready set. The bench drives both in the same cycle on a ready endpoint. It then checks that the data byte was refused and counted as an overrun, and that packet-ready and the count both ended at 0. It also checks that a CPU set in that same cycle loses to tx_done. A separate case makes the auto-setting byte land exactly on the max-packet boundary, where the count-and-compare path and the flag update meet in a single edge.

// File: rtl/usb_ep_regbank_pkg.sv
package usb_ep_regbank_pkg;

    localparam int NUM_EP  = 3;
    localparam int IDX_W   = 2;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int MAXP_W  = 11;
    localparam int MAXP_HI_W = MAXP_W - DATA_W;

    typedef enum logic [ADDR_W-1:0] {
        A_INDEX   = 3'd0,
        A_MAXP_LO = 3'd1,
        A_MAXP_HI = 3'd2,
        A_CTRL_HI = 3'd3,
        A_CTRL_LO = 3'd4,
        A_FIFO    = 3'd5,
        A_CNT_HI  = 3'd6,
        A_SPARE   = 3'd7
    } reg_addr_e;

    // control-low bit positions
    localparam int B_READY   = 0;
    localparam int B_FLUSH   = 1;
    localparam int B_OVERRUN = 2;
    // control-high bit position
    localparam int B_AUTOSET = 7;

    typedef struct packed {
        logic maxp_lo;
        logic maxp_hi;
        logic ctrl_hi;
        logic ctrl_lo;
        logic data;
    } ep_wr_t;

    typedef struct packed {
        logic [MAXP_W-1:0] maxp;
        logic              autoset;
        logic              ready;
        logic              overrun;
        logic [MAXP_W-1:0] count;
    } ep_view_t;

    function automatic logic [DATA_W-1:0] pack_ctrl_lo(input ep_view_t v);
        logic [DATA_W-1:0] r;
        r            = '0;
        r[B_READY]   = v.ready;
        r[B_OVERRUN] = v.overrun;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] hi_bits(input logic [MAXP_W-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[MAXP_HI_W-1:0] = v[MAXP_W-1:DATA_W];
        return r;
    endfunction

endpackage

// File: rtl/usb_ep_wr_decode.sv
module usb_ep_wr_decode
    import usb_ep_regbank_pkg::*;
#(
    parameter int N_EP = NUM_EP
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    output logic              idx_we,
    output ep_wr_t [N_EP-1:0] ep_we
);
    ep_wr_t sel;

    always_comb begin
        sel         = '0;
        idx_we      = 1'b0;
        if (wr) begin
            unique case (reg_addr_e'(addr))
                A_INDEX:   idx_we      = 1'b1;
                A_MAXP_LO: sel.maxp_lo = 1'b1;
                A_MAXP_HI: sel.maxp_hi = 1'b1;
                A_CTRL_HI: sel.ctrl_hi = 1'b1;
                A_CTRL_LO: sel.ctrl_lo = 1'b1;
                A_FIFO:    sel.data    = 1'b1;
                default:   sel         = '0;
            endcase
        end
    end

    for (genvar e = 0; e < N_EP; e++) begin : g_route
        assign ep_we[e] = (int'(idx) == e) ? sel : '0;
    end
endmodule

// File: rtl/usb_ep_in_state.sv
module usb_ep_in_state
    import usb_ep_regbank_pkg::*;
#(
    parameter bit HAS_MAXP = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  ep_wr_t            we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tx_done,
    output ep_view_t          view
);
    logic [MAXP_W-1:0] maxp_q;
    logic              autoset_q;
    logic              ready_q;
    logic              overrun_q;
    logic [MAXP_W-1:0] count_q;
    logic [MAXP_W-1:0] count_inc;
    logic              flush_cmd;
    logic              set_cmd;
    logic              hit_max;

    assign count_inc = count_q + MAXP_W'(1);
    assign flush_cmd = we.ctrl_lo && wdata[B_FLUSH];
    assign set_cmd   = we.ctrl_lo && wdata[B_READY];
    assign hit_max   = autoset_q && (maxp_q != '0) && (count_inc == maxp_q);

    if (HAS_MAXP) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst) begin
                maxp_q    <= '0;
                autoset_q <= 1'b0;
            end else begin
                if (we.maxp_lo) maxp_q[DATA_W-1:0] <= wdata;
                if (we.maxp_hi) maxp_q[MAXP_W-1:DATA_W] <= wdata[MAXP_HI_W-1:0];
                if (we.ctrl_hi) autoset_q <= wdata[B_AUTOSET];
            end
        end
    end else begin : g_nocfg
        assign maxp_q    = '0;
        assign autoset_q = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q   <= 1'b0;
            overrun_q <= 1'b0;
            count_q   <= '0;
        end else if (flush_cmd) begin
            ready_q   <= 1'b0;
            overrun_q <= 1'b0;
            count_q   <= '0;
        end else if (tx_done) begin
            ready_q <= 1'b0;
            count_q <= '0;
            if (we.data && ready_q) overrun_q <= 1'b1;
        end else begin
            if (we.data) begin
                if (ready_q) begin
                    overrun_q <= 1'b1;
                end else begin
                    count_q <= count_inc;
                    if (hit_max) ready_q <= 1'b1;
                end
            end
            if (set_cmd) ready_q <= 1'b1;
        end
    end

    assign view.maxp    = maxp_q;
    assign view.autoset = autoset_q;
    assign view.ready   = ready_q;
    assign view.overrun = overrun_q;
    assign view.count   = count_q;
endmodule

// File: rtl/usb_ep_rd_mux.sv
module usb_ep_rd_mux
    import usb_ep_regbank_pkg::*;
#(
    parameter int N_EP = NUM_EP
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [IDX_W-1:0]    idx,
    input  ep_view_t [N_EP-1:0] views,
    output logic [DATA_W-1:0]   rdata
);
    ep_view_t cur;
    logic     valid;

    always_comb begin
        cur   = '0;
        valid = 1'b0;
        for (int e = 0; e < N_EP; e++) begin
            if (int'(idx) == e) begin
                cur   = views[e];
                valid = 1'b1;
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (reg_addr_e'(addr))
            A_INDEX:   rdata = DATA_W'(idx);
            A_MAXP_LO: rdata = cur.maxp[DATA_W-1:0];
            A_MAXP_HI: rdata = hi_bits(cur.maxp);
            A_CTRL_HI: rdata = {cur.autoset, {(DATA_W-1){1'b0}}};
            A_CTRL_LO: rdata = pack_ctrl_lo(cur);
            A_FIFO:    rdata = cur.count[DATA_W-1:0];
            A_CNT_HI:  rdata = hi_bits(cur.count);
            default:   rdata = '0;
        endcase
        if (!valid && addr != A_INDEX) rdata = '0;
    end
endmodule

// File: rtl/usb_ep_regbank.sv
module usb_ep_regbank
    import usb_ep_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [2:0]        tx_done,
    output logic [2:0]        pkt_ready
);
    logic [IDX_W-1:0]      idx_q;
    logic                  idx_we;
    ep_wr_t   [NUM_EP-1:0] ep_we;
    ep_view_t [NUM_EP-1:0] views;
    logic     [NUM_EP-1:0] ep_overrun;

    always_ff @(posedge clk) begin
        if (rst)         idx_q <= '0;
        else if (idx_we) idx_q <= bus_wdata[IDX_W-1:0];
    end

    usb_ep_wr_decode #(.N_EP(NUM_EP)) u_dec (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .idx    (idx_q),
        .idx_we (idx_we),
        .ep_we  (ep_we)
    );

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        usb_ep_in_state #(.HAS_MAXP(e != 0)) u_ep (
            .clk     (clk),
            .rst     (rst),
            .we      (ep_we[e]),
            .wdata   (bus_wdata),
            .tx_done (tx_done[e]),
            .view    (views[e])
        );
        assign pkt_ready[e]  = views[e].ready;
        assign ep_overrun[e] = views[e].overrun;
    end

    usb_ep_rd_mux #(.N_EP(NUM_EP)) u_rd (
        .addr  (bus_addr),
        .idx   (idx_q),
        .views (views),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/usb_ep_regbank_chk.sv
module usb_ep_regbank_chk
    import usb_ep_regbank_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [2:0]        bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic [2:0]        tx_done,
    input logic [2:0]        pkt_ready,
    input logic [IDX_W-1:0]  idx_q,
    input logic [NUM_EP-1:0] ep_overrun
);
    // R1: unused index hides every per-endpoint address
    assert_idx3_silent_R1: assert property (@(posedge clk) disable iff (rst)
        (idx_q == 2'd3 && bus_addr != 3'd0) |-> bus_rdata == 8'h00);

    // R8: flush bit never reads back as 1
    assert_flush_reads0_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd4) |-> !bus_rdata[1]);

    // R4: endpoint 0 has no config registers visible
    assert_ep0_reserved_R4: assert property (@(posedge clk) disable iff (rst)
        (idx_q == 2'd0 && bus_addr inside {3'd1, 3'd2, 3'd3}) |-> bus_rdata == 8'h00);

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        // R9: transmit-done always wins
        assert_txdone_clears_R9: assert property (@(posedge clk) disable iff (rst)
            tx_done[e] |=> !pkt_ready[e]);

        // R8: flush on the indexed endpoint clears ready and overrun
        assert_flush_clears_R8: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == 3'd4 && bus_wdata[1] && int'(idx_q) == e)
            |=> (!pkt_ready[e] && !ep_overrun[e]));

        // R10: refused write to a ready endpoint marks overrun
        assert_overrun_R10: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == 3'd5 && int'(idx_q) == e && pkt_ready[e])
            |=> ep_overrun[e]);

        // R5: writes aimed at another endpoint leave this ready flag alone
        assert_isolated_R5: assert property (@(posedge clk) disable iff (rst)
            (int'(idx_q) != e && !tx_done[e]) |=> $stable(pkt_ready[e]));

        // R6/R7: ready only rises after a data byte or an explicit set on this endpoint
        assert_ready_cause_R6: assert property (@(posedge clk) disable iff (rst)
            $rose(pkt_ready[e]) |-> ($past(int'(idx_q) == e && bus_wr &&
                ((bus_addr == 3'd5) || (bus_addr == 3'd4 && bus_wdata[0])))));
    end
endmodule

bind usb_ep_regbank usb_ep_regbank_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .tx_done    (tx_done),
    .pkt_ready  (pkt_ready),
    .idx_q      (idx_q),
    .ep_overrun (ep_overrun)
);

// File: tb/usb_ep_regbank_bench.sv
`timescale 1ns/1ps
module usb_ep_regbank_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] bus_addr;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [2:0] tx_done;
    logic [2:0] pkt_ready;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    usb_ep_regbank u_usb_ep_regbank (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tx_done   (tx_done),
        .pkt_ready (pkt_ready)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic pulse_done(input logic [2:0] m);
        @(negedge clk);
        tx_done = m;
        @(negedge clk);
        tx_done = '0;
    endtask

    task automatic get_count(output int c);
        logic [7:0] lo, hi;
        rd(3'd5, lo);
        rd(3'd6, hi);
        c = {hi[2:0], lo};
    endtask

    task automatic set_maxp(input int mp);
        wr(3'd1, mp[7:0]);
        wr(3'd2, {5'b0, mp[10:8]});
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int e = 0; e < 3; e++) begin
            wr(3'd0, 8'(e));
            for (int a = 1; a <= 6; a++) begin
                rd(3'(a), d);
                check("R2 reset value", d, 0);
            end
        end
        check("R2 pkt_ready reset", pkt_ready, 0);
        wr(3'd0, 8'd0);
    endtask

    task automatic t_index;
        logic [7:0] d;
        wr(3'd0, 8'hFE);
        rd(3'd0, d);
        check("R1 index readback", d, 8'h02);
        wr(3'd0, 8'h03);
        rd(3'd0, d);
        check("R1 index 3 readback", d, 8'h03);
        wr(3'd1, 8'h55);
        wr(3'd4, 8'h01);
        wr(3'd5, 8'h11);
        for (int a = 1; a <= 7; a++) begin
            rd(3'(a), d);
            check("R1 index 3 reads zero", d, 0);
        end
        check("R1 index 3 writes ignored", pkt_ready, 0);
        for (int e = 1; e < 3; e++) begin
            wr(3'd0, 8'(e));
            rd(3'd1, d);
            check("R1 no leak from index 3", d, 0);
        end
    endtask

    task automatic t_maxp;
        logic [7:0] d;
        wr(3'd0, 8'd1);
        wr(3'd1, 8'hA5);
        wr(3'd2, 8'hFF);
        rd(3'd1, d);
        check("R3 maxp low byte", d, 8'hA5);
        rd(3'd2, d);
        check("R3 maxp high bits, reserved zero", d, 8'h07);
        wr(3'd0, 8'd2);
        set_maxp(11'h3C2);
        rd(3'd1, d);
        check("R5 ep2 maxp low", d, 8'hC2);
        rd(3'd2, d);
        check("R5 ep2 maxp high", d, 8'h03);
        wr(3'd0, 8'd1);
        rd(3'd1, d);
        check("R5 ep1 maxp kept", d, 8'hA5);
        rd(3'd2, d);
        check("R5 ep1 maxp high kept", d, 8'h07);
    endtask

    task automatic t_ep0;
        logic [7:0] d;
        wr(3'd0, 8'd0);
        wr(3'd1, 8'h40);
        wr(3'd2, 8'h07);
        wr(3'd3, 8'h80);
        rd(3'd1, d); check("R4 ep0 maxp lo", d, 0);
        rd(3'd2, d); check("R4 ep0 maxp hi", d, 0);
        rd(3'd3, d); check("R4 ep0 ctrl hi", d, 0);
        for (int i = 0; i < 3; i++) wr(3'd5, 8'(i));
        check("R4 ep0 no auto-set", pkt_ready[0], 0);
        wr(3'd4, 8'h01);
        check("R7 ep0 manual set", pkt_ready[0], 1);
        wr(3'd4, 8'h02);
        check("R8 ep0 flush", pkt_ready[0], 0);
    endtask

    task automatic t_autoset;
        int c;
        logic [7:0] d;
        wr(3'd0, 8'd2);
        set_maxp(4);
        wr(3'd3, 8'h80);
        rd(3'd3, d);
        check("R6 auto-set readback", d, 8'h80);
        for (int i = 0; i < 3; i++) wr(3'd5, 8'(i));
        check("R7 short packet not ready", pkt_ready[2], 0);
        get_count(c);
        check("R11 count after 3", c, 3);
        wr(3'd5, 8'hEE);
        check("R6 ready at max", pkt_ready, 3'b100);
        rd(3'd4, d);
        check("R11 ctrl ready bit", d, 8'h01);
        get_count(c);
        check("R11 count at max", c, 4);
        wr(3'd0, 8'd1);
        check("R5 index change keeps ready", pkt_ready[2], 1);
        wr(3'd0, 8'd2);
        pulse_done(3'b100);
        check("R9 tx_done clears ready", pkt_ready[2], 0);
        get_count(c);
        check("R9 tx_done clears count", c, 0);
        // boundary: a count of 260 crosses into the high byte
        set_maxp(260);
        for (int i = 0; i < 259; i++) wr(3'd5, 8'(i));
        check("R6 not ready at 259", pkt_ready[2], 0);
        get_count(c);
        check("R11 count 259", c, 259);
        wr(3'd5, 8'h00);
        check("R6 ready at 260", pkt_ready[2], 1);
        pulse_done(3'b100);
    endtask

    task automatic t_manual;
        logic [7:0] d;
        int c;
        wr(3'd0, 8'd1);
        set_maxp(2);
        wr(3'd3, 8'h00);
        for (int i = 0; i < 5; i++) wr(3'd5, 8'(i));
        check("R7 auto-set off no ready", pkt_ready[1], 0);
        wr(3'd4, 8'h00);
        check("R7 write 0 leaves ready", pkt_ready[1], 0);
        wr(3'd4, 8'h01);
        check("R7 manual set", pkt_ready[1], 1);
        wr(3'd4, 8'h00);
        check("R7 write 0 does not clear", pkt_ready[1], 1);
        wr(3'd5, 8'h99);
        get_count(c);
        check("R10 count unchanged", c, 5);
        rd(3'd4, d);
        check("R10 overrun set", d, 8'h05);
        pulse_done(3'b010);
        rd(3'd4, d);
        check("R10 overrun sticky past tx_done", d, 8'h04);
        wr(3'd4, 8'h02);
        rd(3'd4, d);
        check("R8 flush clears overrun, reads 0", d, 8'h00);
        get_count(c);
        check("R8 flush clears count", c, 0);
    endtask

    task automatic t_collide;
        logic [7:0] d;
        int c;
        wr(3'd0, 8'd1);
        wr(3'd4, 8'h01);
        @(negedge clk);
        bus_addr = 3'd5; bus_wdata = 8'h12; bus_wr = 1'b1; tx_done = 3'b010;
        @(negedge clk);
        bus_wr = 1'b0; tx_done = '0;
        check("R12 ready cleared", pkt_ready[1], 0);
        get_count(c);
        check("R12 count zero", c, 0);
        rd(3'd4, d);
        check("R12 overrun set", d, 8'h04);
        wr(3'd4, 8'h02);
        @(negedge clk);
        bus_addr = 3'd4; bus_wdata = 8'h01; bus_wr = 1'b1; tx_done = 3'b010;
        @(negedge clk);
        bus_wr = 1'b0; tx_done = '0;
        check("R9 tx_done beats CPU set", pkt_ready[1], 0);
    endtask

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; tx_done = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_index;
        t_maxp;
        t_ep0;
        t_autoset;
        t_manual;
        t_collide;
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule